// File: doc/BRIEF.md
# SPI Flash Programmed-Command Sequencer

This block drives a serial flash port for commands that software sets up field by field. When `start` is pulsed while the block is idle, it takes a copy of the command fields: opcode, command type, address, data byte count, write data, prefix opcode and the atomic flag. It then runs the command on the port in SPI mode 0, with the serial clock at half the system clock and every byte sent most significant bit first. Bytes read back from the flash are collected in a parallel data buffer. A level `done` flag reports that the whole operation has finished on the port.

In atomic mode, one start runs a chain of cycles. First comes a one-byte prefix cycle using the programmable prefix opcode. Next comes the programmed command itself. After that, the block issues status-read cycles (opcode 0x05) until the flash reports that it is no longer busy. The block does not look at what the programmed opcode means, so any opcode can be wrapped this way. Chip select is held high for a minimum number of system clocks between the cycles of a chain.

The burst length is limited by the data buffer. The count field is only wide enough to address the buffer, so a count larger than the buffer cannot be expressed.

Top module: `flash_cmd_seq`

## Requirements
- R1: After reset `cs_n` is 1, `sck` is 0, `mosi` is 0, and both `done` and `busy` are 0.
- R2: `sck` is low whenever `cs_n` is high. Each bit lasts two system clocks: one clock with `sck` low, then one with `sck` high. `mosi` changes only while `sck` is low. `miso` is sampled at the end of the high clock.
- R3: A programmed cycle sends the opcode first. If `op_type[1]` is 1, the 24-bit address follows, MSB first. The type encoding is: 00 read without address, 01 write without address, 10 read with address, 11 write with address.
- R4: A `byte_cnt` value of N moves N+1 data bytes after the header. Chip select stays low for exactly 2 × (header bits + 8·(N+1)) clocks.
- R5: On a write (`op_type[0]`=1), data byte k is taken from `wr_data[8k+7:8k]`, with byte 0 sent first. On a read, `mosi` is 0 during the data bytes.
- R6: On a read, the k-th data byte received is stored in `rd_data[8k+7:8k]`, with its first-received bit as the MSB.
- R7: In atomic mode, the first cycle is an 8-bit cycle that carries only `prefix_op`. The programmed cycle follows it.
- R8: In atomic mode, after the programmed cycle the block issues 16-bit cycles: opcode 0x05, then one status byte read back. It repeats them while bit 0 of the returned status is 1 and stops after the first status with bit 0 equal to 0. This happens for any programmed opcode.
- R9: Between two cycles of one operation, `cs_n` stays high for at least GAP_CLKS system clocks (default 2).
- R10: `done` is cleared and `busy` is set by an accepted start. `done` is set only once the last cycle has ended with `cs_n` high.
- R11: A `start` pulse while `busy` is 1 is ignored. Changes to the command inputs during an operation do not alter it.
- R12: Status bytes read during polling do not change `rd_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin an operation (accepted only when idle) |
| atomic | input | 1 | Run prefix, command and status polling as one chain |
| opcode | input | 8 | Programmed command opcode |
| prefix_op | input | 8 | Opcode of the prefix cycle in atomic mode |
| op_type | input | 2 | Bit 1: address present; bit 0: write direction |
| addr | input | 24 | Flash address, sent MSB first |
| byte_cnt | input | 3 | Data byte count minus one |
| wr_data | input | 64 | Write buffer, byte 0 in bits 7:0 |
| rd_data | output | 64 | Read buffer, byte 0 in bits 7:0 |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Last operation has finished |
| sck | output | 1 | Serial clock, mode 0 |
| cs_n | output | 1 | Active-low chip select |
| mosi | output | 1 | Serial data to flash |
| miso | input | 1 | Serial data from flash |

## Verification
The bench uses the default parameters: an 8-byte buffer, a 3-byte address and a 2-clock minimum gap. With these values, every count from 1 to 8 bytes, both header lengths and all four type codes can be reached. The flash model can report busy for zero to several polls, which covers both a poll that ends at once and a poll that repeats. Each frame on the wire, its length in clocks, the gap between cycles and the contents of the read buffer are compared with values the bench computes itself. A `start` pulse and changed fields in the middle of an operation check that the committed command is kept.

// File: rtl/fcs_pkg.sv
package fcs_pkg;
   localparam int OPC_W = 8;
   localparam logic [OPC_W-1:0] STATUS_RD_OPC = 8'h05;

   typedef enum logic [1:0] {
      PH_PREFIX = 2'd0,
      PH_MAIN   = 2'd1,
      PH_POLL   = 2'd2
   } phase_t;

   typedef enum logic [1:0] {
      SQ_IDLE   = 2'd0,
      SQ_LAUNCH = 2'd1,
      SQ_RUN    = 2'd2,
      SQ_GAP    = 2'd3
   } seq_state_t;

   typedef enum logic [1:0] {
      SH_IDLE = 2'd0,
      SH_LO   = 2'd1,
      SH_HI   = 2'd2
   } sh_state_t;

   function automatic logic type_has_addr(input logic [1:0] t);
      return t[1];
   endfunction

   function automatic logic type_is_write(input logic [1:0] t);
      return t[0];
   endfunction
endpackage

// File: rtl/fcs_frame_build.sv
module fcs_frame_build
   import fcs_pkg::*;
#(
   parameter int BUF_BYTES  = 8,
   parameter int ADDR_BYTES = 3,
   localparam int ADDR_W = 8 * ADDR_BYTES,
   localparam int DBITS  = 8 * BUF_BYTES,
   localparam int CNT_W  = $clog2(BUF_BYTES),
   localparam int TXW    = OPC_W + ADDR_W + DBITS,
   localparam int BCW    = $clog2(TXW + 1)
) (
   input  phase_t             phase,
   input  logic [OPC_W-1:0]   opc,
   input  logic [OPC_W-1:0]   pfx,
   input  logic [1:0]         otype,
   input  logic [ADDR_W-1:0]  adr,
   input  logic [CNT_W-1:0]   cnt,
   input  logic [DBITS-1:0]   wdata,
   output logic [TXW-1:0]     tx_vec,
   output logic [BCW-1:0]     tx_bits,
   output logic [BCW-1:0]     hdr_bits
);
   logic [DBITS-1:0] data_seq;
   logic [DBITS-1:0] data_out;
   logic [BCW-1:0]   main_hdr;
   logic [BCW-1:0]   main_data;

   // byte 0 goes on the wire first, so it sits at the top of the sequence
   for (genvar gi = 0; gi < BUF_BYTES; gi++) begin : g_order
      assign data_seq[(BUF_BYTES-1-gi)*8 +: 8] = wdata[gi*8 +: 8];
   end

   assign data_out  = type_is_write(otype) ? data_seq : '0;
   assign main_hdr  = type_has_addr(otype) ? BCW'(OPC_W + ADDR_W) : BCW'(OPC_W);
   assign main_data = (BCW'(cnt) + BCW'(1)) << 3;

   always_comb begin
      tx_vec   = '0;
      tx_bits  = BCW'(OPC_W);
      hdr_bits = BCW'(OPC_W);
      unique case (phase)
         PH_PREFIX: begin
            tx_vec   = {pfx, {(ADDR_W + DBITS){1'b0}}};
            tx_bits  = BCW'(OPC_W);
         end
         PH_POLL: begin
            tx_vec   = {STATUS_RD_OPC, {(ADDR_W + DBITS){1'b0}}};
            tx_bits  = BCW'(OPC_W + 8);
         end
         default: begin
            if (type_has_addr(otype))
               tx_vec = {opc, adr, data_out};
            else
               tx_vec = {opc, data_out, {ADDR_W{1'b0}}};
            tx_bits  = main_hdr + main_data;
            hdr_bits = main_hdr;
         end
      endcase
   end
endmodule

// File: rtl/fcs_shifter.sv
module fcs_shifter
   import fcs_pkg::*;
#(
   parameter int TXW      = 96,
   parameter int GAP_CLKS = 2,
   localparam int BCW     = $clog2(TXW + 1),
   localparam int HCW     = $clog2(GAP_CLKS + 1)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            go,
   input  logic [TXW-1:0]  tx_vec,
   input  logic [BCW-1:0]  tx_bits,
   input  logic            miso,
   output logic            sck,
   output logic            cs_n,
   output logic            mosi,
   output logic            smp,
   output logic            smp_bit,
   output logic [BCW-1:0]  smp_pos,
   output logic            fin
);
   sh_state_t        st;
   logic [TXW-1:0]   sreg;
   logic [BCW-1:0]   cnt;
   logic [BCW-1:0]   nb;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= SH_IDLE;
         sck     <= 1'b0;
         cs_n    <= 1'b1;
         mosi    <= 1'b0;
         sreg    <= '0;
         cnt     <= '0;
         nb      <= '0;
         smp     <= 1'b0;
         smp_bit <= 1'b0;
         smp_pos <= '0;
         fin     <= 1'b0;
      end else begin
         smp <= 1'b0;
         fin <= 1'b0;
         unique case (st)
            SH_IDLE: begin
               if (go) begin
                  st   <= SH_LO;
                  cs_n <= 1'b0;
                  mosi <= tx_vec[TXW-1];
                  sreg <= tx_vec << 1;
                  cnt  <= '0;
                  nb   <= tx_bits;
               end
            end
            SH_LO: begin
               sck <= 1'b1;
               st  <= SH_HI;
            end
            default: begin
               sck     <= 1'b0;
               smp     <= 1'b1;
               smp_bit <= miso;
               smp_pos <= cnt;
               if (cnt == nb - BCW'(1)) begin
                  st   <= SH_IDLE;
                  cs_n <= 1'b1;
                  mosi <= 1'b0;
                  fin  <= 1'b1;
               end else begin
                  cnt  <= cnt + BCW'(1);
                  mosi <= sreg[TXW-1];
                  sreg <= sreg << 1;
                  st   <= SH_LO;
               end
            end
         endcase
      end
   end

   // checker state: idle-time of chip select and rising-edge count per frame
   logic [HCW-1:0] hi_cnt;
   logic [BCW-1:0] rise_cnt;
   logic           sck_d;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hi_cnt   <= HCW'(GAP_CLKS);
         rise_cnt <= '0;
         sck_d    <= 1'b0;
      end else begin
         sck_d <= sck;
         if (!cs_n) hi_cnt <= '0;
         else if (hi_cnt != HCW'(GAP_CLKS)) hi_cnt <= hi_cnt + HCW'(1);
         if (go && st == SH_IDLE) rise_cnt <= '0;
         else if (sck && !sck_d) rise_cnt <= rise_cnt + BCW'(1);
      end
   end

   AST_SCK_LOW_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n |-> !sck) else $error("sck high with chip select released"); // R2
   AST_MOSI_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      sck |-> $stable(mosi)) else $error("mosi moved while sck high"); // R2
   AST_GAP_MIN: assert property (@(posedge clk) disable iff (!rst_n)
      (go && st == SH_IDLE) |-> hi_cnt >= HCW'(GAP_CLKS)) else $error("chip select gap too short"); // R9
   AST_BIT_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
      fin |-> rise_cnt == nb) else $error("clock count differs from frame length"); // R4
endmodule

// File: rtl/fcs_rx_capture.sv
module fcs_rx_capture #(
   parameter int BUF_BYTES = 8,
   parameter int TXW       = 96,
   localparam int DBITS    = 8 * BUF_BYTES,
   localparam int IDXW     = $clog2(DBITS),
   localparam int BCW      = $clog2(TXW + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cap_en,
   input  logic             smp,
   input  logic             smp_bit,
   input  logic [BCW-1:0]   smp_pos,
   input  logic [BCW-1:0]   hdr_bits,
   output logic [DBITS-1:0] rd_data
);
   logic [BCW-1:0]  k;
   logic            in_range;
   logic [IDXW-1:0] idx;

   assign k        = smp_pos - hdr_bits;
   assign in_range = (smp_pos >= hdr_bits) && (k < BCW'(DBITS));
   // byte k/8, bit 7-(k%8): first bit of each byte lands in its MSB
   assign idx      = {k[IDXW-1:3], ~k[2:0]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rd_data <= '0;
      else if (cap_en && smp && in_range) rd_data[idx] <= smp_bit;
   end

   AST_CAPTURE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      !cap_en |=> $stable(rd_data)) else $error("read buffer changed outside a read"); // R12
endmodule

// File: rtl/fcs_sequencer.sv
module fcs_sequencer
   import fcs_pkg::*;
#(
   parameter int BUF_BYTES  = 8,
   parameter int ADDR_BYTES = 3,
   parameter int GAP_CLKS   = 2,
   localparam int ADDR_W = 8 * ADDR_BYTES,
   localparam int DBITS  = 8 * BUF_BYTES,
   localparam int CNT_W  = $clog2(BUF_BYTES),
   localparam int GCW    = $clog2(GAP_CLKS + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              atomic,
   input  logic [OPC_W-1:0]  opcode,
   input  logic [OPC_W-1:0]  prefix_op,
   input  logic [1:0]        op_type,
   input  logic [ADDR_W-1:0] addr,
   input  logic [CNT_W-1:0]  byte_cnt,
   input  logic [DBITS-1:0]  wr_data,
   input  logic              fin,
   input  logic              last_bit,
   output logic              go,
   output phase_t            phase,
   output logic [OPC_W-1:0]  opc_q,
   output logic [OPC_W-1:0]  pfx_q,
   output logic [1:0]        type_q,
   output logic [ADDR_W-1:0] adr_q,
   output logic [CNT_W-1:0]  cnt_q,
   output logic [DBITS-1:0]  wdata_q,
   output logic              busy,
   output logic              done
);
   seq_state_t     st;
   logic           atomic_q;
   logic [GCW-1:0] gcnt;

   assign go = (st == SQ_LAUNCH);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= SQ_IDLE;
         phase    <= PH_MAIN;
         atomic_q <= 1'b0;
         opc_q    <= '0;
         pfx_q    <= '0;
         type_q   <= '0;
         adr_q    <= '0;
         cnt_q    <= '0;
         wdata_q  <= '0;
         gcnt     <= '0;
         busy     <= 1'b0;
         done     <= 1'b0;
      end else begin
         unique case (st)
            SQ_IDLE: begin
               if (start) begin
                  atomic_q <= atomic;
                  opc_q    <= opcode;
                  pfx_q    <= prefix_op;
                  type_q   <= op_type;
                  adr_q    <= addr;
                  cnt_q    <= byte_cnt;
                  wdata_q  <= wr_data;
                  phase    <= atomic ? PH_PREFIX : PH_MAIN;
                  busy     <= 1'b1;
                  done     <= 1'b0;
                  st       <= SQ_LAUNCH;
               end
            end
            SQ_LAUNCH: st <= SQ_RUN;
            SQ_RUN: begin
               if (fin) begin
                  gcnt <= '0;
                  unique case (phase)
                     PH_PREFIX: begin
                        phase <= PH_MAIN;
                        st    <= SQ_GAP;
                     end
                     PH_MAIN: begin
                        if (atomic_q) begin
                           phase <= PH_POLL;
                           st    <= SQ_GAP;
                        end else begin
                           busy <= 1'b0;
                           done <= 1'b1;
                           st   <= SQ_IDLE;
                        end
                     end
                     default: begin
                        if (last_bit) begin
                           st <= SQ_GAP;
                        end else begin
                           busy <= 1'b0;
                           done <= 1'b1;
                           st   <= SQ_IDLE;
                        end
                     end
                  endcase
               end
            end
            default: begin
               if (gcnt == GCW'(GAP_CLKS - 1)) st <= SQ_LAUNCH;
               else gcnt <= gcnt + GCW'(1);
            end
         endcase
      end
   end

   AST_FIELDS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> ($stable(opc_q) && $stable(adr_q) && $stable(type_q))) else $error("committed command changed"); // R11
   AST_DONE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(done && busy)) else $error("done and busy together"); // R10
   AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (st == SQ_IDLE && start) |=> (busy && !done)) else $error("accepted start did not clear done"); // R10
endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
   import fcs_pkg::*;
#(
   parameter int BUF_BYTES  = 8,
   parameter int ADDR_BYTES = 3,
   parameter int GAP_CLKS   = 2,
   localparam int ADDR_W = 8 * ADDR_BYTES,
   localparam int DBITS  = 8 * BUF_BYTES,
   localparam int CNT_W  = $clog2(BUF_BYTES),
   localparam int TXW    = OPC_W + ADDR_W + DBITS,
   localparam int BCW    = $clog2(TXW + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              atomic,
   input  logic [7:0]        opcode,
   input  logic [7:0]        prefix_op,
   input  logic [1:0]        op_type,
   input  logic [ADDR_W-1:0] addr,
   input  logic [CNT_W-1:0]  byte_cnt,
   input  logic [DBITS-1:0]  wr_data,
   output logic [DBITS-1:0]  rd_data,
   output logic              busy,
   output logic              done,
   output logic              sck,
   output logic              cs_n,
   output logic              mosi,
   input  logic              miso
);
   if (BUF_BYTES < 2 || (BUF_BYTES & (BUF_BYTES - 1)) != 0) begin : g_bad_buf
      $error("BUF_BYTES must be a power of two of at least 2");
   end
   if (ADDR_BYTES < 1) begin : g_bad_addr
      $error("ADDR_BYTES must be at least 1");
   end
   if (GAP_CLKS < 2) begin : g_bad_gap
      $error("GAP_CLKS must be at least 2");
   end

   logic              go, fin, smp, smp_bit;
   logic [BCW-1:0]    smp_pos, tx_bits, hdr_bits;
   logic [TXW-1:0]    tx_vec;
   phase_t            phase;
   logic [OPC_W-1:0]  opc_q, pfx_q;
   logic [1:0]        type_q;
   logic [ADDR_W-1:0] adr_q;
   logic [CNT_W-1:0]  cnt_q;
   logic [DBITS-1:0]  wdata_q;
   logic              cap_en;

   fcs_sequencer #(.BUF_BYTES(BUF_BYTES), .ADDR_BYTES(ADDR_BYTES), .GAP_CLKS(GAP_CLKS)) u_seq (
      .clk(clk), .rst_n(rst_n), .start(start), .atomic(atomic), .opcode(opcode),
      .prefix_op(prefix_op), .op_type(op_type), .addr(addr), .byte_cnt(byte_cnt),
      .wr_data(wr_data), .fin(fin), .last_bit(smp_bit), .go(go), .phase(phase),
      .opc_q(opc_q), .pfx_q(pfx_q), .type_q(type_q), .adr_q(adr_q), .cnt_q(cnt_q),
      .wdata_q(wdata_q), .busy(busy), .done(done)
   );

   fcs_frame_build #(.BUF_BYTES(BUF_BYTES), .ADDR_BYTES(ADDR_BYTES)) u_frame (
      .phase(phase), .opc(opc_q), .pfx(pfx_q), .otype(type_q), .adr(adr_q),
      .cnt(cnt_q), .wdata(wdata_q), .tx_vec(tx_vec), .tx_bits(tx_bits), .hdr_bits(hdr_bits)
   );

   fcs_shifter #(.TXW(TXW), .GAP_CLKS(GAP_CLKS)) u_shift (
      .clk(clk), .rst_n(rst_n), .go(go), .tx_vec(tx_vec), .tx_bits(tx_bits),
      .miso(miso), .sck(sck), .cs_n(cs_n), .mosi(mosi), .smp(smp),
      .smp_bit(smp_bit), .smp_pos(smp_pos), .fin(fin)
   );

   assign cap_en = (phase == PH_MAIN) && !type_is_write(type_q);

   fcs_rx_capture #(.BUF_BYTES(BUF_BYTES), .TXW(TXW)) u_cap (
      .clk(clk), .rst_n(rst_n), .cap_en(cap_en), .smp(smp), .smp_bit(smp_bit),
      .smp_pos(smp_pos), .hdr_bits(hdr_bits), .rd_data(rd_data)
   );

   AST_DONE_PORT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (cs_n && !sck)) else $error("done while port active"); // R10
   AST_BUSY_COVERS_CS: assert property (@(posedge clk) disable iff (!rst_n)
      !cs_n |-> busy) else $error("chip select low while not busy"); // R10
endmodule

// File: tb/flash_cmd_seq_tb.sv
`timescale 1ns/1ps
module flash_cmd_seq_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0, atomic = 1'b0;
   logic [7:0]  opcode = '0, prefix_op = '0;
   logic [1:0]  op_type = '0;
   logic [23:0] addr = '0;
   logic [2:0]  byte_cnt = '0;
   logic [63:0] wr_data = '0;
   logic [63:0] rd_data;
   logic        busy, done, sck, cs_n, mosi;
   logic        miso = 1'b0;

   always #5 clk = ~clk;

   flash_cmd_seq u_dut (
      .clk(clk), .rst_n(rst_n), .start(start), .atomic(atomic), .opcode(opcode),
      .prefix_op(prefix_op), .op_type(op_type), .addr(addr), .byte_cnt(byte_cnt),
      .wr_data(wr_data), .rd_data(rd_data), .busy(busy), .done(done),
      .sck(sck), .cs_n(cs_n), .mosi(mosi), .miso(miso)
   );

   int checks = 0, fails = 0;
   bit finished = 1'b0;

   task automatic chk(input bit ok, input string req, input logic [95:0] act, input logic [95:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // ---------------- flash model ----------------
   bit          m_atomic;
   int          m_k, m_hdr, m_cyc, m_bitn;
   logic [63:0] m_rd;
   logic [95:0] m_rx;
   logic [95:0] cyc_bits [32];
   int          cyc_len [32];
   int          cyc_low [32];
   int          low_run, hi_run, min_gap;

   function automatic logic pick(input int i);
      logic [7:0] stat;
      int j;
      if (m_atomic && m_cyc >= 2) begin
         if (i < 8 || i > 15) return 1'b0;
         stat = 8'hA4 | {7'd0, (m_cyc - 2) < m_k};
         return stat[7 - (i - 8)];
      end
      if ((m_atomic && m_cyc == 1) || (!m_atomic && m_cyc == 0)) begin
         j = i - m_hdr;
         if (j >= 0 && j < 64) return m_rd[(j / 8) * 8 + 7 - (j % 8)];
      end
      return 1'b0;
   endfunction

   always @(negedge cs_n) begin
      if (m_cyc > 0 && hi_run < min_gap) min_gap = hi_run;
      m_bitn = 0;
      m_rx = '0;
      low_run = 0;
      miso <= #1 pick(0);
   end
   always @(posedge sck) if (!cs_n) begin
      m_rx = {m_rx[94:0], mosi};
      m_bitn++;
   end
   always @(negedge sck) if (!cs_n) miso <= #1 pick(m_bitn);
   always @(posedge cs_n) if (rst_n) begin
      if (m_cyc < 32) begin
         cyc_bits[m_cyc] = m_rx;
         cyc_len[m_cyc] = m_bitn;
         cyc_low[m_cyc] = low_run;
      end
      m_cyc++;
      hi_run = 0;
   end
   always @(negedge clk) begin
      if (cs_n) hi_run++;
      else low_run++;
   end

   // ---------------- expected values ----------------
   function automatic logic [95:0] exp_main(input logic [7:0] op, input logic [1:0] ty,
                                            input logic [23:0] ad, input int n,
                                            input logic [63:0] wd, output int len);
      logic [95:0] v;
      v = {88'd0, op};
      len = 8;
      if (ty[1]) begin
         v = {v[71:0], ad};
         len += 24;
      end
      for (int j = 0; j <= n; j++) begin
         v = {v[87:0], (ty[0] ? wd[j*8 +: 8] : 8'h00)};
         len += 8;
      end
      return v;
   endfunction

   task automatic run_txn(input bit at, input logic [7:0] op, input logic [7:0] pfx,
                          input logic [1:0] ty, input logic [23:0] ad, input int n,
                          input logic [63:0] wd, input logic [63:0] rr, input int k,
                          input bit glitch);
      logic [95:0] ev;
      logic [63:0] mask;
      int el, ncyc, mi;
      m_atomic = at; m_k = k; m_rd = rr; m_hdr = ty[1] ? 32 : 8;
      m_cyc = 0; min_gap = 1000;
      @(negedge clk);
      atomic = at; opcode = op; prefix_op = pfx; op_type = ty; addr = ad;
      byte_cnt = 3'(n); wr_data = wd; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk(!done && busy, "R10 start clears done", {94'd0, done, busy}, 96'd1);
      if (glitch) begin
         repeat (15) @(negedge clk);
         atomic = ~at; opcode = ~op; op_type = ~ty; addr = ~ad; wr_data = ~wd;
         start = 1'b1;
         @(negedge clk);
         start = 1'b0;
      end
      while (!done) @(negedge clk);
      chk(cs_n && !sck, "R10 done only with port idle", {94'd0, cs_n, sck}, 96'd2);
      ncyc = at ? (3 + k) : 1;
      chk(m_cyc == ncyc, "R8/R11 cycle count", 96'(m_cyc), 96'(ncyc));
      mi = at ? 1 : 0;
      if (at) begin
         chk(cyc_len[0] == 8 && cyc_bits[0] == {88'd0, pfx}, "R7 prefix cycle",
             cyc_bits[0], {88'd0, pfx});
         for (int p = 2; p < ncyc && p < 32; p++)
            chk(cyc_len[p] == 16 && cyc_bits[p] == 96'h0500, "R8 status poll frame",
                cyc_bits[p], 96'h0500);
         chk(min_gap >= 2, "R9 chip select gap", 96'(min_gap), 96'd2);
      end
      ev = exp_main(op, ty, ad, n, wd, el);
      chk(cyc_len[mi] == el && cyc_bits[mi] == ev, "R3/R5 main frame", cyc_bits[mi], ev);
      chk(cyc_low[mi] == 2 * el, "R2/R4 clocks with chip select low", 96'(cyc_low[mi]), 96'(2 * el));
      if (!ty[0]) begin
         mask = '0;
         for (int j = 0; j <= n; j++) mask[j*8 +: 8] = 8'hFF;
         chk((rd_data & mask) == (rr & mask), "R6/R12 read buffer", {32'd0, rd_data & mask}, {32'd0, rr & mask});
      end
   endtask

   // ---------------- stimulus ----------------
   initial begin
      void'($urandom(32'h5EED_0C3A));
      repeat (3) @(negedge clk);
      chk(cs_n && !sck && !mosi && !done && !busy, "R1 reset state",
          {91'd0, cs_n, sck, mosi, done, busy}, {91'd0, 5'b10000});
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      chk(cs_n && !done && !busy, "R1 idle after reset", {93'd0, cs_n, done, busy}, 96'd4);

      // directed: each type, shortest and longest bursts
      run_txn(0, 8'h9F, 8'h00, 2'b00, 24'h0, 0, 64'h0, 64'h00000000000000C2, 0, 0);
      run_txn(0, 8'h03, 8'h00, 2'b10, 24'hA5_5A_3C, 7, 64'h0, 64'h8877665544332211, 0, 0);
      run_txn(0, 8'h01, 8'h00, 2'b01, 24'h0, 0, 64'h00000000000000F0, 64'h0, 0, 0);
      run_txn(0, 8'h02, 8'h00, 2'b11, 24'h12_34_56, 7, 64'h0123456789ABCDEF, 64'h0, 0, 0);
      // atomic: ready at first poll, busy for several polls
      run_txn(1, 8'hD8, 8'h06, 2'b10, 24'hFF_00_80, 0, 64'h0, 64'h0, 0, 0);
      run_txn(1, 8'h02, 8'h06, 2'b11, 24'h00_01_00, 3, 64'hDEADBEEFCAFE1234, 64'h0, 3, 0);
      // atomic around a read: polls must not touch the read buffer (R12)
      run_txn(1, 8'h0B, 8'h50, 2'b10, 24'h777777, 5, 64'h0, 64'h5A5A_1357_2468_9BDF, 2, 0);
      // start and new fields in mid-operation are ignored (R11)
      run_txn(0, 8'h02, 8'h00, 2'b11, 24'hC0FFEE, 6, 64'h1122334455667788, 64'h0, 0, 1);
      run_txn(1, 8'h20, 8'h06, 2'b10, 24'h0ABCDE, 1, 64'h0, 64'h0, 2, 1);

      for (int t = 0; t < 30; t++) begin
         run_txn(1'($urandom % 2), 8'($urandom), 8'($urandom), 2'($urandom),
                 24'($urandom), int'($urandom % 8), {$urandom, $urandom},
                 {$urandom, $urandom}, int'($urandom % 4), 1'($urandom % 5 == 0));
      end

      repeat (5) @(negedge clk);
      if (!finished) begin
         finished = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         checks++;
         fails++;
         $display("FAIL watchdog R10 actual=timeout expected=done");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end
endmodule